// File: doc/BRIEF.md
# Beeper-to-PCM Time-Stretching Sound Buffer

This block turns a one-bit beeper port into a stream of 8-bit audio samples for a host that lets guest code run only while the display is blanked. Guest writes to the beeper port arrive in short bursts, so the block does not send them straight to the speaker. It records the latest beeper state on each line tick inside the capture window and stores that state in a circular buffer. Each stored entry also carries a flag that says whether the port was written since the previous capture.

Playback runs on every line tick. Each stored entry is used for several consecutive ticks (four by default), so the burst is spread out over the whole frame. An entry with its flag set drives the sample to full scale (bit 1) or to zero (bit 0). A tick with no fresh write, or with nothing left to play, moves the sample a fixed step toward mid-scale. This removes the DC offset that a beeper left high would otherwise cause.

The port write input and the sample output are plain strobes with no back-pressure. The beeper port has no ready signal because every write is accepted. The sample output has no ready signal because the audio converter must take one sample on every line tick. Overflow of the buffer is therefore resolved inside the block, by dropping the newest capture.

Top module: `beep_stretch_buf`

## Requirements
- R1: While reset is low, and on the first cycle after it, `smp_valid` is 0 and `smp_data` equals mid-scale 0x80. The buffer is empty, the repeat counter is 0 and the pending-write flag is clear.
- R2: A pulse on `beep_valid` only stores `beep_bit` and sets the pending-write flag. `smp_data` changes only in the cycle that follows a line tick.
- R3: A capture happens on a cycle with `line_tick` and `capture_en` both high. It appends one entry made of {written = pending flag OR `beep_valid`, level = `beep_bit` if `beep_valid`, else the stored bit}, then clears the pending flag. A capture whose flag is 0 plays back as decay.
- R4: `smp_valid` is high for exactly the one cycle after each `line_tick`, and low at all other times.
- R5: An entry taken from the buffer applies to REPEAT (4) consecutive line ticks, starting with the tick that takes it. The next entry is taken on the tick after those.
- R6: A tick that applies an entry with written = 1 sets the sample to 0xFF if level is 1, and to 0x00 if level is 0.
- R7: A tick that applies an unwritten entry moves the sample 8 codes toward 0x80 without passing it. A sample within 8 codes of 0x80 becomes exactly 0x80.
- R8: The buffer holds 256 entries. A capture that arrives while it is full is dropped, and the occupancy never exceeds 256.
- R9: A tick that needs a new entry while the buffer is empty treats itself as unwritten (decay, R7) and leaves the repeat counter at 0. The next tick therefore takes the first entry that becomes available.
- R10: When a capture and a take happen on the same tick, the take sees the buffer as it was before that tick's capture.
- R11: Entries play back in the order in which they were captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| beep_valid | input | 1 | Strobe: guest wrote the beeper port this cycle |
| beep_bit | input | 1 | Beeper level written by the guest |
| line_tick | input | 1 | One-cycle pulse per display line |
| capture_en | input | 1 | High during the lines where guest code runs |
| smp_valid | output | 1 | One-cycle strobe marking a new sample |
| smp_data | output | 8 | Unsigned PCM sample, 0x80 is silence |

## Verification
The assertions check the following on every cycle: the one-to-one pairing of line ticks with sample strobes, that the sample holds its value between strobes, and that any sample other than full scale or zero is no farther from mid-scale than the one before and has not crossed it. They also check that the buffer occupancy never goes above its depth, and that it grows only on capture ticks. The bench's reference model is needed to show the rest. That covers the four-fold repetition and its phase after an underflow, the capture order, the meaning of the written flag (including a write on the same cycle as a capture), the dropping of captures when the buffer is full, and the precise clamp at mid-scale.

// File: rtl/beep_pkg.sv
package beep_pkg;

  // One buffered beeper snapshot: was the port written, and at what level.
  typedef struct packed {
    logic written;
    logic level;
  } beep_entry_t;

  localparam beep_entry_t BEEP_IDLE = '{written: 1'b0, level: 1'b0};

endpackage

// File: rtl/beep_capture.sv
module beep_capture
  import beep_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beep_valid,
  input  logic        beep_bit,
  input  logic        line_tick,
  input  logic        capture_en,
  output logic        push_valid,
  output beep_entry_t push_entry
);

  logic state_bit;
  logic pend_q;
  logic eff_bit;
  logic eff_written;

  // A write in the capture cycle itself counts for that capture.
  assign eff_bit     = beep_valid ? beep_bit : state_bit;
  assign eff_written = pend_q | beep_valid;

  assign push_valid        = line_tick & capture_en;
  assign push_entry.written = eff_written;
  assign push_entry.level   = eff_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_bit <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      state_bit <= eff_bit;
      if (push_valid) pend_q <= 1'b0;
      else            pend_q <= eff_written;
    end
  end

endmodule

// File: rtl/beep_ring.sv
module beep_ring
  import beep_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  beep_entry_t   push_entry,
  input  logic          pop_req,
  output beep_entry_t   pop_entry,
  output logic          empty,
  output logic [FW-1:0] fill
);

  localparam logic [FW-1:0] FULL_CNT = FW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  beep_entry_t   store [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          push_ok;
  logic          pop_ok;

  // Full/empty decisions use the occupancy before this cycle's updates.
  assign empty   = (fill == '0);
  assign push_ok = push_valid && (fill != FULL_CNT);
  assign pop_ok  = pop_req && !empty;
  assign pop_entry = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

endmodule

// File: rtl/beep_stretch.sv
module beep_stretch
  import beep_pkg::*;
#(
  parameter int REPEAT = 4,
  localparam int CW = (REPEAT > 1) ? $clog2(REPEAT) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_tick,
  input  logic        empty,
  input  beep_entry_t pop_entry,
  output logic        pop_req,
  output logic        play_valid,
  output beep_entry_t play_entry
);

  localparam logic [CW-1:0] REP_LAST = CW'(REPEAT - 1);

  logic [CW-1:0] rep_q;
  beep_entry_t   held_q;
  logic          need_new;

  assign need_new   = (rep_q == '0);
  assign pop_req    = line_tick && need_new;
  assign play_valid = line_tick;

  always_comb begin
    if (!need_new)   play_entry = held_q;
    else if (!empty) play_entry = pop_entry;
    else             play_entry = BEEP_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_q  <= '0;
      held_q <= BEEP_IDLE;
    end else if (line_tick) begin
      if (need_new) begin
        if (!empty) begin
          held_q <= pop_entry;
          rep_q  <= REP_LAST;
        end
      end else begin
        rep_q <= rep_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcm_shaper.sv
module pcm_shaper
  import beep_pkg::*;
#(
  parameter int SW   = 8,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          play_valid,
  input  beep_entry_t   play_entry,
  output logic          smp_valid,
  output logic [SW-1:0] smp_data
);

  localparam logic [SW-1:0] MID   = SW'(1) << (SW - 1);
  localparam logic [SW-1:0] TOP   = '1;
  localparam logic [SW-1:0] STEPV = SW'(STEP);

  logic [SW-1:0] next_smp;

  function automatic logic [SW-1:0] toward_mid(input logic [SW-1:0] s);
    logic [SW-1:0] r;
    if (s > MID) begin
      r = ((s - MID) <= STEPV) ? MID : s - STEPV;
    end else if (s < MID) begin
      r = ((MID - s) <= STEPV) ? MID : s + STEPV;
    end else begin
      r = MID;
    end
    return r;
  endfunction

  always_comb begin
    if (play_entry.written) next_smp = play_entry.level ? TOP : '0;
    else                    next_smp = toward_mid(smp_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_data  <= MID;
    end else begin
      smp_valid <= play_valid;
      if (play_valid) smp_data <= next_smp;
    end
  end

endmodule

// File: rtl/beep_stretch_buf.sv
module beep_stretch_buf
  import beep_pkg::*;
#(
  parameter int SW     = 8,
  parameter int DEPTH  = 256,
  parameter int REPEAT = 4,
  parameter int STEP   = 8,
  localparam int FW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beep_valid,
  input  logic          beep_bit,
  input  logic          line_tick,
  input  logic          capture_en,
  output logic          smp_valid,
  output logic [SW-1:0] smp_data
);

  logic          push_valid;
  beep_entry_t   push_entry;
  logic          pop_req;
  beep_entry_t   pop_entry;
  logic          ring_empty;
  logic [FW-1:0] fifo_fill;
  logic          play_valid;
  beep_entry_t   play_entry;

  beep_capture u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .beep_valid (beep_valid),
    .beep_bit   (beep_bit),
    .line_tick  (line_tick),
    .capture_en (capture_en),
    .push_valid (push_valid),
    .push_entry (push_entry)
  );

  beep_ring #(.DEPTH(DEPTH)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_entry (push_entry),
    .pop_req    (pop_req),
    .pop_entry  (pop_entry),
    .empty      (ring_empty),
    .fill       (fifo_fill)
  );

  beep_stretch #(.REPEAT(REPEAT)) u_stretch (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_tick  (line_tick),
    .empty      (ring_empty),
    .pop_entry  (pop_entry),
    .pop_req    (pop_req),
    .play_valid (play_valid),
    .play_entry (play_entry)
  );

  pcm_shaper #(.SW(SW), .STEP(STEP)) u_shaper (
    .clk        (clk),
    .rst_n      (rst_n),
    .play_valid (play_valid),
    .play_entry (play_entry),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data)
  );

endmodule

// File: rtl/beep_stretch_buf_chk.sv
module beep_stretch_buf_chk #(
  parameter int SW    = 8,
  parameter int DEPTH = 256,
  parameter int STEP  = 8,
  localparam int FW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_tick,
  input logic          capture_en,
  input logic          smp_valid,
  input logic [SW-1:0] smp_data,
  input logic [FW-1:0] fill
);

  localparam logic [SW-1:0] MID = SW'(1) << (SW - 1);
  localparam logic [SW-1:0] TOP = '1;

  logic [SW-1:0] prev_smp;
  logic [SW-1:0] dist_now;
  logic [SW-1:0] dist_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_smp <= MID;
    else        prev_smp <= smp_data;
  end

  assign dist_now  = (smp_data >= MID) ? smp_data - MID : MID - smp_data;
  assign dist_prev = (prev_smp >= MID) ? prev_smp - MID : MID - prev_smp;

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!smp_valid && smp_data == MID));

  // R4
  a_r4_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick |=> smp_valid);
  a_r4_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !line_tick |=> !smp_valid);

  // R2
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(smp_data));

  // R7
  a_r7_decay_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_data != '0 && smp_data != TOP) |->
      (dist_now <= dist_prev && (dist_prev - dist_now) <= SW'(STEP) &&
       (smp_data == MID || ((smp_data > MID) == (prev_smp > MID)))));

  // R8
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));

  // R3
  a_r3_grow_on_capture_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_tick && capture_en) |=> fill <= $past(fill));

endmodule

bind beep_stretch_buf beep_stretch_buf_chk #(.SW(SW), .DEPTH(DEPTH), .STEP(STEP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_tick  (line_tick),
  .capture_en (capture_en),
  .smp_valid  (smp_valid),
  .smp_data   (smp_data),
  .fill       (fifo_fill)
);

// File: tb/beep_stretch_buf_tb_top.sv
module beep_stretch_buf_tb_top;

  localparam int DEPTH = 256;
  localparam int REP   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       beep_valid = 1'b0;
  logic       beep_bit = 1'b0;
  logic       line_tick = 1'b0;
  logic       capture_en = 1'b0;
  logic       smp_valid;
  logic [7:0] smp_data;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  beep_stretch_buf dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .beep_valid (beep_valid),
    .beep_bit   (beep_bit),
    .line_tick  (line_tick),
    .capture_en (capture_en),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data)
  );

  // ---------------- behavioural reference model ----------------
  int q[$];
  int m_bit, m_pend, m_rep, m_cur, m_smp, m_val, m_acc;

  function automatic int decay(input int s);
    if (s > 128) return (s - 128 <= 8) ? 128 : s - 8;
    if (s < 128) return (128 - s <= 8) ? 128 : s + 8;
    return 128;
  endfunction

  always @(posedge clk) begin
    int e_bit, e_flag, osz, use_e;
    if (!rst_n) begin
      q.delete();
      m_bit = 0; m_pend = 0; m_rep = 0; m_cur = 0; m_smp = 128; m_val = 0;
    end else begin
      e_bit  = beep_valid ? int'(beep_bit) : m_bit;
      e_flag = (m_pend != 0 || beep_valid) ? 1 : 0;
      osz    = q.size();
      if (line_tick) begin
        if (m_rep == 0) begin
          if (osz > 0) begin
            m_cur = q.pop_front();
            m_rep = REP - 1;
            use_e = m_cur;
          end else begin
            use_e = 0;
          end
        end else begin
          m_rep = m_rep - 1;
          use_e = m_cur;
        end
        if (use_e >= 2) m_smp = (use_e % 2 == 1) ? 255 : 0;
        else            m_smp = decay(m_smp);
      end
      if (line_tick && capture_en) begin
        if (osz < DEPTH) begin
          q.push_back(e_flag * 2 + e_bit);
          m_acc++;
        end
        m_pend = 0;
      end else begin
        m_pend = e_flag;
      end
      m_bit = e_bit;
      m_val = line_tick ? 1 : 0;
    end
  end

  // Compare with the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    n_checks++;
    if (int'(smp_valid) != m_val || int'(smp_data) != m_smp) begin
      n_fails++;
      $display("FAIL %s model: actual valid=%0d data=%0h expected valid=%0d data=%0h",
               cur_req, smp_valid, smp_data, m_val, m_smp);
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One line tick; returns the sample seen in the following cycle.
  task automatic do_tick(input bit cap, input bit wr, input bit b, output int got);
    @(negedge clk);
    line_tick = 1'b1; capture_en = cap; beep_valid = wr; beep_bit = b;
    @(negedge clk);
    line_tick = 1'b0; capture_en = 1'b0; beep_valid = 1'b0;
    got = int'(smp_data);
    @(negedge clk);
  endtask

  task automatic beep_write(input bit b);
    @(negedge clk);
    beep_valid = 1'b1; beep_bit = b;
    @(negedge clk);
    beep_valid = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // Watchdog
  initial begin
    #1500000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  // ---------------- scenarios ----------------
  initial begin
    int got;
    int full_ticks;
    int acc0;
    repeat (4) @(negedge clk);
    cur_req = "R1";
    check("R1 valid in reset", int'(smp_valid), 0);
    check("R1 data in reset", int'(smp_data), 8'h80);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 data after reset", int'(smp_data), 8'h80);

    // R9: empty buffer stays at mid-scale.
    cur_req = "R9";
    do_tick(1'b0, 1'b0, 1'b0, got);
    check("R9 empty tick", got, 8'h80);

    // R2: writes with no tick do not reach the output.
    cur_req = "R2";
    beep_write(1'b1);
    beep_write(1'b0);
    beep_write(1'b1);
    check("R2 no change without tick", int'(smp_data), 8'h80);
    check("R2 no strobe without tick", int'(smp_valid), 0);

    // R6/R5/R7: captured written 1 plays 4x full scale, then decays.
    cur_req = "R6";
    do_tick(1'b1, 1'b0, 1'b0, got);
    check("R10 capture tick sees empty buffer", got, 8'h80);
    do_tick(1'b0, 1'b0, 1'b0, got);
    check("R6 written one", got, 8'hFF);
    cur_req = "R5";
    for (int i = 0; i < 3; i++) begin
      do_tick(1'b0, 1'b0, 1'b0, got);
      check("R5 repeat", got, 8'hFF);
    end
    cur_req = "R7";
    do_tick(1'b0, 1'b0, 1'b0, got);
    check("R7 first decay step", got, 8'hF7);
    for (int i = 0; i < 14; i++) do_tick(1'b0, 1'b0, 1'b0, got);
    check("R7 last step before mid", got, 8'h87);
    do_tick(1'b0, 1'b0, 1'b0, got);
    check("R7 clamp at mid", got, 8'h80);

    // R3: written 0, then an unwritten capture, played back in order.
    cur_req = "R3";
    beep_write(1'b0);
    do_tick(1'b1, 1'b0, 1'b0, got);
    do_tick(1'b1, 1'b0, 1'b0, got);
    check("R6 written zero", got, 8'h00);
    for (int i = 0; i < 3; i++) do_tick(1'b0, 1'b0, 1'b0, got);
    check("R5 zero repeated", got, 8'h00);
    do_tick(1'b0, 1'b0, 1'b0, got);
    check("R3 unwritten capture decays", got, 8'h08);
    for (int i = 0; i < 20; i++) do_tick(1'b0, 1'b0, 1'b0, got);
    check("R7 low side clamp", got, 8'h80);

    // R10/R11: burst with writes in the capture cycle, mixed order.
    cur_req = "R11";
    for (int i = 0; i < 12; i++) begin
      if (i % 3 == 0)      do_tick(1'b1, 1'b1, 1'b1, got);
      else if (i % 3 == 1) do_tick(1'b1, 1'b1, 1'b0, got);
      else                 do_tick(1'b1, 1'b0, 1'b0, got);
    end
    for (int i = 0; i < 60; i++) do_tick(1'b0, 1'b0, 1'b0, got);
    check("R11 burst drained to mid", got, 8'h80);

    // R8: long capture window overfills the buffer; newest are dropped.
    cur_req = "R8";
    acc0 = m_acc;
    full_ticks = 0;
    for (int i = 0; i < 400; i++) begin
      do_tick(1'b1, 1'b1, 1'(i % 2), got);
      if (got == 0 || got == 255) full_ticks++;
    end
    for (int i = 0; i < 1200; i++) begin
      do_tick(1'b0, 1'b0, 1'b0, got);
      if (got == 0 || got == 255) full_ticks++;
    end
    check("R8 captures were dropped", (m_acc - acc0 < 400) ? 1 : 0, 1);
    check("R8 played entries equal accepted", full_ticks, REP * (m_acc - acc0));
    check("R8 drained to mid", got, 8'h80);

    cur_req = "R4";
    @(negedge clk);
    check("R4 no strobe when idle", int'(smp_valid), 0);
    finish_up();
  end

endmodule